// File: doc/BRIEF.md
# Write-Protect Command Sequence Decoder

This block sits beside the page-program controller of a byte-loaded flash array. It watches each byte-load event, made of an address and a data byte, and looks for fixed command prefixes written to two magic addresses. A recognised prefix can unlock one program cycle, arm or disarm a persistent write-protect flag, or enter and leave an identification mode. In identification mode, fixed manufacturer and device codes replace array read data.

A load window is the group of byte loads that the page controller collects before it starts a program cycle. The controller pulses `prog_go_i` when the window closes and pulses `prog_end_i` when the program period finishes. At `prog_go_i` the decoder tells the controller one of three things: store the page, run the program timer without storing (a blocked write while protected), or do nothing (a window that held only command bytes). A change to the protect flag is applied only at the end of the program cycle that carried the arming or disarming prefix. The protect flag is not cleared by `rst_ni`. Only the factory-initialise input `fac_init_i` clears it. Identification mode, the matcher and any pending change are volatile and are cleared by `rst_ni`.

Top module: `wp_seq_decoder`

## Requirements
- R1: Command bytes are matched on address bits 14..0 only. A prefix that has address bit 15 set is recognised in the same way as one with bit 15 clear.
- R2: While unprotected, a window of plain data bytes gives `prog_store_o`=1 and `prog_dummy_o`=0 from the cycle after `prog_go_i` until the cycle after `prog_end_i`.
- R3: The window AA@5555, 55@2AAA, A0@5555 followed by data bytes gives `prog_store_o`=1. `prot_o` keeps its old value during the program cycle and is 1 from the cycle after `prog_end_i`.
- R4: While protected, a data window with no unlock prefix gives `prog_dummy_o`=1 and `prog_store_o`=0, and `prot_o` stays 1.
- R5: While protected, the three-byte unlock prefix followed by data gives `prog_store_o`=1, and `prot_o` stays 1.
- R6: The six-byte prefix AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 followed by data gives `prog_store_o`=1. `prot_o` is 0 from the cycle after `prog_end_i`, whatever its value was before.
- R7: A byte that breaks a partly matched prefix returns the matcher to idle. That byte and every later byte in the window count as page data, so while protected the window is blocked (`prog_dummy_o`=1).
- R8: The prefix AA@5555, 55@2AAA, 90@5555 sets `id_mode_o` exactly PAUSE_CYC clock edges after the edge that takes the third byte. In identification mode, `rd_data_o` is MFR_CODE (0x1F) when `rd_a0_i`=0 and DEV_CODE (0x5D) when `rd_a0_i`=1.
- R9: The prefix AA@5555, 55@2AAA, F0@5555 clears `id_mode_o` exactly PAUSE_CYC edges after the third byte. Outside identification mode, `rd_data_o` equals `arr_data_i`.
- R10: `rst_ni` low clears `id_mode_o`, the matcher and the program outputs, and leaves `prot_o` unchanged.
- R11: `fac_init_i` high at a clock edge clears `prot_o`.
- R12: A window that held only command bytes gives `prog_store_o`=0 and `prog_dummy_o`=0 after `prog_go_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset of the volatile state |
| fac_init_i | input | 1 | Factory initialise; clears the protect flag |
| load_i | input | 1 | One-cycle byte-load strobe |
| addr_i | input | ADDR_W | Load address |
| data_i | input | 8 | Load data |
| prog_go_i | input | 1 | Load window closed; program cycle starts |
| prog_end_i | input | 1 | Program period finished |
| rd_a0_i | input | 1 | Bit 0 of the read address |
| arr_data_i | input | 8 | Read data from the array |
| rd_data_o | output | 8 | Read data after the identification override |
| prot_o | output | 1 | Persistent write-protect flag |
| id_mode_o | output | 1 | Identification mode active |
| prog_store_o | output | 1 | Current program cycle stores the page |
| prog_dummy_o | output | 1 | Current program cycle runs the timer only |

## Verification
The bench checks the timing of the protect flag around the program cycle: the flag must still show its old value between `prog_go_i` and `prog_end_i`. A design that applied the change at window close would fail that check. Prefixes with address bit 15 set would be missed by a full-width compare. A broken prefix that left the matcher half-armed would store data on a protected part instead of producing a dummy cycle. The identification pause is checked one edge before and one edge at its end, which catches an off-by-one counter. A reset while protected catches a design that puts the persistent flag on the power-on reset.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int DW     = 8;
  localparam int CMD_AW = 15;

  localparam logic [CMD_AW-1:0] A_MAGIC0 = 15'h5555;
  localparam logic [CMD_AW-1:0] A_MAGIC1 = 15'h2AAA;

  localparam logic [DW-1:0] D_KEY0  = 8'hAA;
  localparam logic [DW-1:0] D_KEY1  = 8'h55;
  localparam logic [DW-1:0] D_UNLK  = 8'hA0;
  localparam logic [DW-1:0] D_EXT   = 8'h80;
  localparam logic [DW-1:0] D_DISA  = 8'h20;
  localparam logic [DW-1:0] D_IDIN  = 8'h90;
  localparam logic [DW-1:0] D_IDOUT = 8'hF0;

  typedef enum logic [3:0] {
    M_IDLE, M_K0, M_K1, M_EXT, M_K2, M_K3, M_UNL, M_DIS, M_DONE
  } mstate_e;
endpackage

// File: rtl/wp_cmd_match.sv
module wp_cmd_match
  import wp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [CMD_AW-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  output logic              has_data_o,
  output logic              unl_o,
  output logic              dis_o,
  output logic              id_req_o,
  output logic              id_val_o
);
  mstate_e st_q, st_d;
  logic    data_q, data_d;
  logic    hit0, hit1;

  assign hit0 = (addr_i == A_MAGIC0);
  assign hit1 = (addr_i == A_MAGIC1);

  always_comb begin
    st_d     = st_q;
    data_d   = data_q;
    id_req_o = 1'b0;
    id_val_o = 1'b0;
    if (load_i && !data_q) begin
      unique case (st_q)
        M_IDLE: if (hit0 && data_i == D_KEY0) st_d = M_K0;
                else data_d = 1'b1;
        M_K0: if (hit1 && data_i == D_KEY1) st_d = M_K1;
              else begin st_d = M_IDLE; data_d = 1'b1; end
        M_K1: begin
          if (hit0 && data_i == D_UNLK) st_d = M_UNL;
          else if (hit0 && data_i == D_EXT) st_d = M_EXT;
          else if (hit0 && data_i == D_IDIN) begin
            st_d = M_DONE; id_req_o = 1'b1; id_val_o = 1'b1;
          end else if (hit0 && data_i == D_IDOUT) begin
            st_d = M_DONE; id_req_o = 1'b1;
          end else begin st_d = M_IDLE; data_d = 1'b1; end
        end
        M_EXT: if (hit0 && data_i == D_KEY0) st_d = M_K2;
               else begin st_d = M_IDLE; data_d = 1'b1; end
        M_K2: if (hit1 && data_i == D_KEY1) st_d = M_K3;
              else begin st_d = M_IDLE; data_d = 1'b1; end
        M_K3: if (hit0 && data_i == D_DISA) st_d = M_DIS;
              else begin st_d = M_IDLE; data_d = 1'b1; end
        default: data_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= M_IDLE;
      data_q <= 1'b0;
    end else if (clr_i) begin
      st_q   <= M_IDLE;
      data_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      data_q <= data_d;
    end
  end

  assign has_data_o = data_q;
  assign unl_o      = (st_q == M_UNL);
  assign dis_o      = (st_q == M_DIS);
endmodule

// File: rtl/wp_prot_state.sv
module wp_prot_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fac_init_i,
  input  logic go_i,
  input  logic end_i,
  input  logic has_data_i,
  input  logic unl_i,
  input  logic dis_i,
  output logic prot_o,
  output logic store_o,
  output logic dummy_o
);
  logic prot_q, store_q, dummy_q, pend_en_q, pend_dis_q;
  logic active, auth;

  assign active = store_q | dummy_q;
  assign auth   = unl_i | dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q    <= 1'b0;
      dummy_q    <= 1'b0;
      pend_en_q  <= 1'b0;
      pend_dis_q <= 1'b0;
    end else if (active && end_i) begin
      store_q    <= 1'b0;
      dummy_q    <= 1'b0;
      pend_en_q  <= 1'b0;
      pend_dis_q <= 1'b0;
    end else if (!active && go_i && has_data_i) begin
      store_q    <= !prot_q || auth;
      dummy_q    <= prot_q && !auth;
      pend_en_q  <= unl_i;
      pend_dis_q <= dis_i;
    end
  end

  // persistent flag: only factory init clears it, not the power-on reset
  always_ff @(posedge clk_i) begin
    if (fac_init_i)                      prot_q <= 1'b0;
    else if (rst_ni && active && end_i) begin
      if (pend_dis_q)                    prot_q <= 1'b0;
      else if (pend_en_q)                prot_q <= 1'b1;
    end
  end

  assign prot_o  = prot_q;
  assign store_o = store_q;
  assign dummy_o = dummy_q;
endmodule

// File: rtl/wp_id_ctrl.sv
module wp_id_ctrl
  import wp_pkg::*;
#(
  parameter int          PAUSE_CYC = 32,
  parameter logic [7:0]  MFR_CODE  = 8'h1F,
  parameter logic [7:0]  DEV_CODE  = 8'h5D
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          id_req_i,
  input  logic          id_val_i,
  input  logic          rd_a0_i,
  input  logic [DW-1:0] arr_data_i,
  output logic          id_mode_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int CW = $clog2(PAUSE_CYC + 1);
  localparam logic [CW-1:0] PAUSE_LD = CW'(PAUSE_CYC);

  logic [CW-1:0] cnt_q;
  logic          pend_q, id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      id_q   <= 1'b0;
    end else if (id_req_i) begin
      cnt_q  <= PAUSE_LD;
      pend_q <= id_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) id_q <= pend_q;
    end
  end

  assign id_mode_o = id_q;
  assign rd_data_o = id_q ? (rd_a0_i ? DEV_CODE : MFR_CODE) : arr_data_i;
endmodule

// File: rtl/wp_seq_decoder.sv
module wp_seq_decoder
  import wp_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter int         PAUSE_CYC = 32,
  parameter logic [7:0] MFR_CODE  = 8'h1F,
  parameter logic [7:0] DEV_CODE  = 8'h5D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fac_init_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic              prog_go_i,
  input  logic              prog_end_i,
  input  logic              rd_a0_i,
  input  logic [DW-1:0]     arr_data_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              prot_o,
  output logic              id_mode_o,
  output logic              prog_store_o,
  output logic              prog_dummy_o
);
  logic has_data, unl, dis, id_req, id_val;

  generate
    if (ADDR_W > CMD_AW) begin : g_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^addr_i[ADDR_W-1:CMD_AW];
    end
  endgenerate

  wp_cmd_match u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (prog_go_i),
    .load_i     (load_i),
    .addr_i     (addr_i[CMD_AW-1:0]),
    .data_i     (data_i),
    .has_data_o (has_data),
    .unl_o      (unl),
    .dis_o      (dis),
    .id_req_o   (id_req),
    .id_val_o   (id_val)
  );

  wp_prot_state u_prot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fac_init_i (fac_init_i),
    .go_i       (prog_go_i),
    .end_i      (prog_end_i),
    .has_data_i (has_data),
    .unl_i      (unl),
    .dis_i      (dis),
    .prot_o     (prot_o),
    .store_o    (prog_store_o),
    .dummy_o    (prog_dummy_o)
  );

  wp_id_ctrl #(
    .PAUSE_CYC (PAUSE_CYC),
    .MFR_CODE  (MFR_CODE),
    .DEV_CODE  (DEV_CODE)
  ) u_id (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .id_req_i   (id_req),
    .id_val_i   (id_val),
    .rd_a0_i    (rd_a0_i),
    .arr_data_i (arr_data_i),
    .id_mode_o  (id_mode_o),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/wp_seq_decoder_chk.sv
module wp_seq_decoder_chk #(
  parameter logic [7:0] MFR_CODE = 8'h1F,
  parameter logic [7:0] DEV_CODE = 8'h5D
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fac_init_i,
  input logic       prog_go_i,
  input logic       prog_end_i,
  input logic       rd_a0_i,
  input logic [7:0] arr_data_i,
  input logic [7:0] rd_data_o,
  input logic       prot_o,
  input logic       id_mode_o,
  input logic       prog_store_o,
  input logic       prog_dummy_o
);
  // R2, R4: a cycle either stores or is a dummy, never both
  p_store_dummy_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_store_o && prog_dummy_o));

  // R3, R6: protect flag moves only at program end or factory init
  p_prot_at_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prot_o) |-> $past(prog_end_i || fac_init_i));

  // R4: blocked cycles only happen while protected
  p_dummy_needs_prot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_dummy_o |-> prot_o);

  // R2: a store cycle begins only after the window closes
  p_store_after_go_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_store_o) |-> $past(prog_go_i));

  // R8: identification codes on the read path
  p_id_codes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_mode_o |-> rd_data_o == (rd_a0_i ? DEV_CODE : MFR_CODE));

  // R9: array data passes through outside identification mode
  p_rd_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_mode_o |-> rd_data_o == arr_data_i);
endmodule

bind wp_seq_decoder wp_seq_decoder_chk #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_chk (.*);

// File: tb/sim_wp_seq_decoder.sv
module sim_wp_seq_decoder;
  localparam int PAUSE = 32;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fac_init_i = 1'b1;
  logic       load_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic       prog_go_i = 1'b0;
  logic       prog_end_i = 1'b0;
  logic       rd_a0_i = 1'b0;
  logic [7:0] arr_data_i = 8'h3C;
  logic [7:0] rd_data_o;
  logic       prot_o, id_mode_o, prog_store_o, prog_dummy_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wp_seq_decoder #(.ADDR_W(16), .PAUSE_CYC(PAUSE)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fac_init_i(fac_init_i), .load_i(load_i),
    .addr_i(addr_i), .data_i(data_i), .prog_go_i(prog_go_i), .prog_end_i(prog_end_i),
    .rd_a0_i(rd_a0_i), .arr_data_i(arr_data_i), .rd_data_o(rd_data_o),
    .prot_o(prot_o), .id_mode_o(id_mode_o), .prog_store_o(prog_store_o),
    .prog_dummy_o(prog_dummy_o)
  );

  // [7:5] prefix kind 0 none 1 unlock 2 disable 3 broken, [4] addr bit 15 set,
  // [3] store, [2] dummy, [1] prot before end, [0] prot after end
  localparam int NV = 9;
  localparam logic [7:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R2
    {3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R3
    {3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R4
    {3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R5
    {3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R7
    {3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R1
    {3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R6
    {3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R2
    {3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}   // R6, R1
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ld(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    load_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); prog_go_i = 1'b1;
    @(negedge clk); prog_go_i = 1'b0;
  endtask

  task automatic fin();
    @(negedge clk); prog_end_i = 1'b1;
    @(negedge clk); prog_end_i = 1'b0;
  endtask

  task automatic prefix3(input logic [15:0] hi, input logic [7:0] last);
    ld(hi | 16'h5555, 8'hAA);
    ld(hi | 16'h2AAA, 8'h55);
    ld(hi | 16'h5555, last);
  endtask

  task automatic page();
    for (int i = 0; i < 4; i++) ld(16'h0100 + 16'(i), 8'(i * 3 + 7));
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    fac_init_i = 1'b0;
    wait_cyc(1);
    rst_ni = 1'b1;
    wait_cyc(1);
    // reset state
    chk("R10 store after reset", {7'd0, prog_store_o}, 8'd0);
    chk("R10 dummy after reset", {7'd0, prog_dummy_o}, 8'd0);
    chk("R10 id after reset", {7'd0, id_mode_o}, 8'd0);
    chk("R11 prot after init", {7'd0, prot_o}, 8'd0);
    chk("R9 passthrough", rd_data_o, 8'h3C);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] hi;
      hi = VEC[v][4] ? 16'h8000 : 16'h0000;
      unique case (VEC[v][7:5])
        3'd1: prefix3(hi, 8'hA0);
        3'd2: begin prefix3(hi, 8'h80); prefix3(hi, 8'h20); end
        3'd3: begin ld(16'h5555, 8'hAA); ld(16'h2AAA, 8'h55); ld(16'h0004, 8'h12); end
        default: ;
      endcase
      page();
      go();
      chk($sformatf("R2-table v%0d store", v), {7'd0, prog_store_o}, {7'd0, VEC[v][3]});
      chk($sformatf("R4-table v%0d dummy", v), {7'd0, prog_dummy_o}, {7'd0, VEC[v][2]});
      chk($sformatf("R3-table v%0d prot during cycle", v), {7'd0, prot_o}, {7'd0, VEC[v][1]});
      fin();
      chk($sformatf("R6-table v%0d prot after end", v), {7'd0, prot_o}, {7'd0, VEC[v][0]});
    end

    // arm protection again for the reset test
    prefix3(16'h0000, 8'hA0); page(); go(); fin();
    chk("R3 prot armed", {7'd0, prot_o}, 8'd1);

    // R8: identification entry and pause length
    prefix3(16'h0000, 8'h90);
    wait_cyc(PAUSE - 1);
    chk("R8 id before pause ends", {7'd0, id_mode_o}, 8'd0);
    wait_cyc(1);
    chk("R8 id after pause", {7'd0, id_mode_o}, 8'd1);
    go();
    chk("R12 command-only store", {7'd0, prog_store_o}, 8'd0);
    chk("R12 command-only dummy", {7'd0, prog_dummy_o}, 8'd0);
    rd_a0_i = 1'b0; #1;
    chk("R8 manufacturer code", rd_data_o, 8'h1F);
    rd_a0_i = 1'b1; #1;
    chk("R8 device code", rd_data_o, 8'h5D);

    // R10: reset drops identification, keeps protection
    @(negedge clk); rst_ni = 1'b0;
    wait_cyc(2); rst_ni = 1'b1;
    wait_cyc(1);
    chk("R10 id cleared", {7'd0, id_mode_o}, 8'd0);
    chk("R10 prot kept", {7'd0, prot_o}, 8'd1);
    rd_a0_i = 1'b0; arr_data_i = 8'hC5; #1;
    chk("R9 passthrough after reset", rd_data_o, 8'hC5);

    // R9: entry then exit
    prefix3(16'h0000, 8'h90); wait_cyc(PAUSE); go();
    chk("R9 id set before exit", {7'd0, id_mode_o}, 8'd1);
    prefix3(16'h0000, 8'hF0);
    wait_cyc(PAUSE - 1);
    chk("R9 id held until pause ends", {7'd0, id_mode_o}, 8'd1);
    wait_cyc(1);
    chk("R9 id cleared", {7'd0, id_mode_o}, 8'd0);
    go();

    // R11: factory init clears protection
    @(negedge clk); fac_init_i = 1'b1;
    @(negedge clk); fac_init_i = 1'b0;
    chk("R11 prot cleared", {7'd0, prot_o}, 8'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule